// File: doc/BRIEF.md
# Serial-Addressed Octal Register Bank

This block is the digital front end of an eight-channel, serially programmed converter. A 12-bit command word is shifted in one bit per rising clock edge. The first four bits of the word name a target channel and the last eight bits carry the value for it. When the load strobe is sampled high, the value held in the shift chain is copied into the addressed channel register. The eight channel registers drive parallel outputs that the downstream converters would use.

The far end of the shift chain drives a serial output. Several devices can therefore share one data line in a daisy chain: a word pushed through one device reaches the next device twelve clocks later. Address codes outside the channel range are no-operations, so a command can be parked in one device of a chain while another device takes its own word.

Reset puts every channel at midscale. Each channel also raises a single-cycle update flag when a load writes to it.

Top module: `octal_serial_regbank`

## Requirements
- R1: A synchronous active-low reset clears the shift chain (so `sdo` reads 0), sets all eight channel values to 8'h80 and clears every update flag.
- R2: The command word is 12 bits, shifted most significant bit first. The first four bits sampled form the address (bit 11 down to bit 8 of the word) and the last eight form the data (bit 7 down to bit 0), so the data LSB is the final bit sampled.
- R3: A load with address 1 through 8 writes the data field into channel 0 through 7 respectively (channel index = address - 1).
- R4: A load with address 0 or 9 through 15 changes no channel value and raises no update flag.
- R5: `load` is sampled on the rising clock edge and uses the shift-chain contents present before that edge. Shifting continues during a load, so a load held for two edges applies two successive words.
- R6: After the edge that samples bit n on `sdi`, `sdo` shows the bit sampled eleven edges earlier (n-11), i.e. the bit the next device in a chain samples twelve edges after it entered; it shows 0 while that bit predates reset.
- R7: A channel value stays unchanged on every edge that does not load a valid address naming that channel.
- R8: The update flag of a channel is high for exactly the one cycle that follows the loading edge, and at most one flag is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial and system clock, rising-edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| sdi | input | 1 | Serial command input |
| load | input | 1 | Active-high strobe that transfers the data field to the addressed channel |
| sdo | output | 1 | Serial output from the far end of the shift chain |
| chan_val | output | 8x8 | Packed channel values, element i is channel i |
| chan_upd | output | 8 | One-cycle update flags, bit i for channel i |

## Verification
An address decode that is off by one shows up on the cycle after the load edge. The value lands in a neighbouring element of `chan_val`, and the wrong bit of `chan_upd` pulses. A bit-order or field-split error in the shift chain corrupts the stored value in that same cycle: for example, 8'h01 reads back as 8'h80 or as bits shifted into the address. A wrong chain length or tap is visible on `sdo` eleven edges after the first distinctive bit is sampled, and it does not depend on any load. A stale or sticky update flag appears one cycle after the load, when the flag should already have dropped.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
    localparam int unsigned CH_N    = 8;
    localparam int unsigned DATA_W  = 8;
    localparam int unsigned ADDR_W  = 4;
    localparam int unsigned WORD_W  = ADDR_W + DATA_W;
    localparam logic [DATA_W-1:0] MID_VAL = DATA_W'(1) << (DATA_W - 1);
endpackage

// File: rtl/rb_shift_chain.sv
module rb_shift_chain #(
    parameter int unsigned WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sdi,
    output logic [WORD_W-1:0] word_o,
    output logic              sdo
);
    typedef struct packed {
        logic [WORD_W-1:0] sr;
    } chain_t;

    chain_t c_d, c_q;

    always_comb begin
        c_d    = c_q;
        c_d.sr = {c_q.sr[WORD_W-2:0], sdi};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign word_o = c_q.sr;
    assign sdo    = c_q.sr[WORD_W-1];

    // R6
    entry_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> c_q.sr[0] == $past(sdi));
    // R6
    chain_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> c_q.sr[WORD_W-1:1] == $past(c_q.sr[WORD_W-2:0]));
endmodule

// File: rtl/rb_addr_decode.sv
module rb_addr_decode #(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned CH_N   = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              load_i,
    output logic [CH_N-1:0]   sel_o,
    output logic              noop_o
);
    for (genvar g = 0; g < CH_N; g++) begin : g_sel
        assign sel_o[g] = load_i && (addr_i == ADDR_W'(g + 1));
    end

    assign noop_o = load_i && ((addr_i == '0) || (32'(addr_i) > 32'(CH_N)));

    always_comb begin
        // R4
        noop_quiet_chk: assert (!noop_o || sel_o == '0);
        // R3
        sel_onehot_chk: assert ($onehot0(sel_o));
    end
endmodule

// File: rtl/rb_channel_bank.sv
module rb_channel_bank #(
    parameter int unsigned        CH_N    = 8,
    parameter int unsigned        DATA_W  = 8,
    parameter logic [DATA_W-1:0]  RST_VAL = 8'h80
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [CH_N-1:0]              sel_i,
    input  logic [DATA_W-1:0]            data_i,
    output logic [CH_N-1:0][DATA_W-1:0]  chan_o,
    output logic [CH_N-1:0]              upd_o
);
    typedef struct packed {
        logic [CH_N-1:0][DATA_W-1:0] chan;
        logic [CH_N-1:0]             upd;
    } bank_t;

    localparam bank_t RST_BANK = '{chan: {CH_N{RST_VAL}}, upd: '0};

    bank_t b_d, b_q;

    always_comb begin
        b_d     = b_q;
        b_d.upd = '0;
        for (int i = 0; i < CH_N; i++) begin
            if (sel_i[i]) begin
                b_d.chan[i] = data_i;
                b_d.upd[i]  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) b_q <= RST_BANK;
        else        b_q <= b_d;
    end

    assign chan_o = b_q.chan;
    assign upd_o  = b_q.upd;

    // R8
    upd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(b_q.upd));
    // R8
    upd_follows_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> b_q.upd == $past(sel_i));
    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sel_i) == '0) |-> $stable(b_q.chan));
endmodule

// File: rtl/octal_serial_regbank.sv
module octal_serial_regbank
    import regbank_pkg::*;
#(
    parameter int unsigned CHN   = CH_N,
    parameter int unsigned DW    = DATA_W,
    parameter int unsigned AW    = ADDR_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sdi,
    input  logic                    load,
    output logic                    sdo,
    output logic [CHN-1:0][DW-1:0]  chan_val,
    output logic [CHN-1:0]          chan_upd
);
    localparam int unsigned WW = AW + DW;
    localparam logic [DW-1:0] MID = DW'(1) << (DW - 1);

    logic [WW-1:0]  word;
    logic [AW-1:0]  addr;
    logic [DW-1:0]  data;
    logic [CHN-1:0] sel;
    logic           noop;

    rb_shift_chain #(.WORD_W(WW)) u_chain (
        .clk    (clk),
        .rst_n  (rst_n),
        .sdi    (sdi),
        .word_o (word),
        .sdo    (sdo)
    );

    assign addr = word[WW-1:DW];
    assign data = word[DW-1:0];

    rb_addr_decode #(.ADDR_W(AW), .CH_N(CHN)) u_dec (
        .addr_i (addr),
        .load_i (load),
        .sel_o  (sel),
        .noop_o (noop)
    );

    rb_channel_bank #(.CH_N(CHN), .DATA_W(DW), .RST_VAL(MID)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_i  (sel),
        .data_i (data),
        .chan_o (chan_val),
        .upd_o  (chan_upd)
    );

    for (genvar g = 0; g < CHN; g++) begin : g_tgt
        // R3
        load_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (load && addr == AW'(g + 1)) |=> (chan_val[g] == $past(data) && chan_upd[g]));
    end

    // R4
    noop_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && (addr == '0 || 32'(addr) > 32'(CHN))) |=> (chan_upd == '0 && $stable(chan_val)));
endmodule

// File: tb/tb_octal_serial_regbank.sv
module tb_octal_serial_regbank;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 12;

    typedef struct packed {
        logic [3:0] a;
        logic [7:0] d;
        logic       hit;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{4'h1, 8'h11, 1'b1},
        '{4'h2, 8'h22, 1'b1},
        '{4'h8, 8'hFE, 1'b1},
        '{4'h0, 8'h55, 1'b0},
        '{4'h9, 8'h66, 1'b0},
        '{4'hF, 8'h77, 1'b0},
        '{4'h3, 8'h00, 1'b1},
        '{4'h4, 8'hFF, 1'b1},
        '{4'h5, 8'h5A, 1'b1},
        '{4'h6, 8'hA5, 1'b1},
        '{4'h7, 8'h01, 1'b1},
        '{4'h1, 8'h3C, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sdi = 1'b0;
    logic load = 1'b0;
    logic sdo;
    logic [7:0][7:0] chan_val;
    logic [7:0] chan_upd;

    logic [7:0] model [8];
    int nchk = 0;
    int nfail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    octal_serial_regbank dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .sdi      (sdi),
        .load     (load),
        .sdo      (sdo),
        .chan_val (chan_val),
        .chan_upd (chan_upd)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic patbit(int n);
        return logic'(((n * 5 + 3) % 7) < 3);
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; load = 1'b0; sdi = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++) model[i] = 8'h80;
    endtask

    task automatic check_reset_state();
        for (int i = 0; i < 8; i++) chk("R1 chan", 32'(chan_val[i]), 32'h80);
        chk("R1 upd", 32'(chan_upd), 0);
        chk("R1 sdo", 32'(sdo), 0);
    endtask

    task automatic send(logic [11:0] w);
        for (int i = 11; i >= 0; i--) begin
            sdi = w[i];
            @(negedge clk);
        end
    endtask

    task automatic check_all(string req);
        for (int i = 0; i < 8; i++) chk(req, 32'(chan_val[i]), 32'(model[i]));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        do_reset();
        // R1: state straight after reset
        check_reset_state();

        // Vector walk: R2, R3, R4, R7, R8
        for (int v = 0; v < NV; v++) begin
            logic [7:0] exp_upd;
            send({VECS[v].a, VECS[v].d});
            load = 1'b1; sdi = 1'b1;
            @(negedge clk);
            load = 1'b0; sdi = 1'b0;
            exp_upd = '0;
            if (VECS[v].hit) begin
                model[VECS[v].a - 1] = VECS[v].d;
                exp_upd[VECS[v].a - 1] = 1'b1;
            end
            check_all(VECS[v].hit ? "R3/R2/R7 chan" : "R4 chan");
            chk(VECS[v].hit ? "R8 upd" : "R4 upd", 32'(chan_upd), 32'(exp_upd));
            @(negedge clk);
            chk("R8 upd drop", 32'(chan_upd), 0);
            check_all("R7 hold");
        end

        // R5: load held two edges applies two successive words
        send(12'h340);
        load = 1'b1; sdi = 1'b1;
        @(negedge clk);
        chk("R5 first", 32'(chan_val[2]), 32'h40);
        sdi = 1'b0;
        @(negedge clk);
        load = 1'b0;
        model[2] = 8'h40;
        model[5] = 8'h81;
        check_all("R5 second");
        chk("R5 upd", 32'(chan_upd), 32'h20);

        // R6: serial pass-through, fresh chain after reset
        do_reset();
        check_reset_state();
        for (int n = 0; n < 30; n++) begin
            sdi = patbit(n);
            @(negedge clk);
            chk("R6 sdo", 32'(sdo), (n >= 11) ? 32'(patbit(n - 11)) : 0);
        end
        check_all("R7 shift only");

        // R1: reset after writes restores midscale
        send(12'h7AB);
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        chk("R3 pre-reset", 32'(chan_val[6]), 32'hAB);
        do_reset();
        check_reset_state();

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule